// File: doc/BRIEF.md
# Busy-Flag Converter Readback Controller

This block sits on the host side of a serial link to an 18-bit sampling converter that runs in its four-wire mode with a busy flag. When a start pulse arrives while the block is idle, it raises the mode-select line and then the convert line. It lowers the mode-select line after a fixed number of cycles, while the conversion is still running. It then watches the shared serial data input for the low level that marks the end of conversion.

When that low level appears, the block generates 19 serial clock periods from a divided system clock. It throws away the first sampled bit, which is the busy marker, and shifts in the next 18 bits MSB first. It presents the word together with a one-cycle done strobe and drops the convert line.

If the busy low does not arrive within a bounded time, the block aborts. It drops the convert line and pulses an error strobe instead.

Top module: `adc_busy_rd`

## Requirements
- R1: While reset is asserted and right after it, `cvt_o`, `sel_o`, `sck_o`, `done_o` and `err_o` are all low.
- R2: `sel_o` is already high in the cycle before `cvt_o` rises, and it is still high in the cycle where `cvt_o` rises.
- R3: `sel_o` falls exactly SDI_HOLD cycles after `cvt_o` rises. SDI_HOLD must be at least 1 and below TMIN, and `sel_o` stays low until the busy low is seen.
- R4: `cvt_o` stays high from its rise until readback ends. It falls in the same cycle as the `done_o` pulse.
- R5: No edge appears on `sck_o` before `miso_i` has been seen low after `sel_o` fell.
- R6: A readback has exactly 19 `sck_o` periods. Each period starts with a rising edge, and each high and low phase lasts DIV system clock cycles.
- R7: Bits are sampled at the rising `sck_o` edges. The first sample (the busy marker) is discarded, and the next 18 samples form `data_o` with the first one in bit 17.
- R8: `done_o` is high for exactly one cycle per completed readback. `data_o` holds the captured word from that cycle on.
- R9: If `miso_i` is still high TMAX cycles after `cvt_o` rose, then `cvt_o` falls at that cycle and `err_o` pulses for one cycle. In that case there is no `sck_o` edge and no `done_o`.
- R10: A start pulse that arrives while a cycle is in progress has no effect: no second conversion follows, and the current word is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion and readback |
| cvt_o | output | 1 | Convert line to the converter |
| sel_o | output | 1 | Mode-select line, high at the convert edge |
| sck_o | output | 1 | Serial clock |
| miso_i | input | 1 | Shared serial data and busy line (pulled high when floating) |
| data_o | output | 18 | Last captured result |
| done_o | output | 1 | One-cycle strobe when data_o is updated |
| err_o | output | 1 | One-cycle strobe on conversion timeout |

## Verification
A wrong phase counter shows up at once as a serial clock half-period that is not DIV cycles long. A wrong bit counter appears at the end of the frame as a readback of 18 or 20 periods, or as a word shifted by one position. If the busy-wait state mishandles the input, the clock starts early or the timeout fires. The error strobe then appears TMAX cycles after the convert edge instead of a done strobe, so it is visible within one conversion time.

// File: rtl/adc_busy_rd.sv
`timescale 1ns/1ps
module adc_busy_rd #(
  parameter int W        = 18,
  parameter int DIV      = 2,
  parameter int SDI_HOLD = 3,
  parameter int TMIN     = 10,
  parameter int TMAX     = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  output logic         cvt_o,
  output logic         sel_o,
  output logic         sck_o,
  input  logic         miso_i,
  output logic [W-1:0] data_o,
  output logic         done_o,
  output logic         err_o
);
  localparam int HW = $clog2(DIV + 1);
  localparam int TW = $clog2(TMAX + 1);
  localparam int BW = $clog2(W + 1);

  if (SDI_HOLD < 1 || SDI_HOLD >= TMIN || TMIN >= TMAX || DIV < 1) begin : g_bad_cfg
    $error("adc_busy_rd: need 1 <= SDI_HOLD < TMIN < TMAX and DIV >= 1");
  end

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_CONV, S_WAIT, S_READ} st_t;
  st_t st;

  logic          cvt_q, sel_q, sck_q, done_q, err_q;
  logic [TW-1:0] tcnt;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bitn;
  logic [W-1:0]  sh, data_q;

  assign cvt_o  = cvt_q;
  assign sel_o  = sel_q;
  assign sck_o  = sck_q;
  assign data_o = data_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cvt_q <= 1'b0; sel_q <= 1'b0; sck_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;
      tcnt <= '0; hcnt <= '0; bitn <= '0;
      sh <= '0; data_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          sel_q <= 1'b1;
          st    <= S_SETUP;
        end
        S_SETUP: begin
          cvt_q <= 1'b1;
          tcnt  <= '0;
          st    <= S_CONV;
        end
        S_CONV: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(SDI_HOLD - 1)) begin
            sel_q <= 1'b0;
            st    <= S_WAIT;
          end
        end
        S_WAIT: begin
          tcnt <= tcnt + 1'b1;
          if (!miso_i) begin
            hcnt <= HW'(DIV - 1);
            bitn <= '0;
            st   <= S_READ;
          end else if (tcnt == TW'(TMAX - 1)) begin
            err_q <= 1'b1;
            cvt_q <= 1'b0;
            st    <= S_IDLE;
          end
        end
        S_READ: begin
          if (hcnt != '0) begin
            hcnt <= hcnt - 1'b1;
          end else begin
            hcnt  <= HW'(DIV - 1);
            sck_q <= !sck_q;
            if (!sck_q) begin
              if (bitn != '0) sh <= {sh[W-2:0], miso_i};
            end else if (bitn == BW'(W)) begin
              data_q <= sh;
              done_q <= 1'b1;
              cvt_q  <= 1'b0;
              st     <= S_IDLE;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_sel_at_cvt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cvt_q) |-> sel_q);
  p_sel_low_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT || st == S_READ) |-> !sel_q);
  p_cvt_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cvt_q) |-> (done_q || err_q));
  p_sck_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> (cvt_q && !sel_q));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_err_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!done_q && !sck_q && !cvt_q));
endmodule

// File: tb/sim_adc_busy_rd.sv
`timescale 1ns/1ps
module sim_adc_busy_rd;
  localparam int DIV = 2, SDI_HOLD = 3, TMIN = 10, TMAX = 60;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b1;
  logic cvt, sel, sck, done, err;
  logic [17:0] data;

  adc_busy_rd #(.W(18), .DIV(DIV), .SDI_HOLD(SDI_HOLD), .TMIN(TMIN), .TMAX(TMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cvt_o(cvt), .sel_o(sel),
    .sck_o(sck), .miso_i(miso), .data_o(data), .done_o(done), .err_o(err));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and port monitor
  logic [17:0] d_word;
  int d_time = -1, d_cnt = 0, d_falls = 0;
  bit d_arm = 0, d_read = 0;
  bit pc = 0, ps = 0, psel = 0;
  int age, sel_age, fall_age, rises, early, badhalf, since, edges, ndone, nerr, late_sel, rises_cvt;
  bit sel_at, sel_before, fall_done;
  logic [17:0] got;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cvt && !pc) begin
        age = 0; rises_cvt++; sel_at = sel; sel_before = psel;
        if (sel && d_time >= 0) begin d_arm = 1; d_cnt = d_time; end
      end else if (pc) age++;
      if (psel && !sel && cvt) sel_age = age;
      if (pc && !cvt) begin fall_age = age; fall_done = done; miso = 1'b1; d_read = 0; d_arm = 0; end
      if (d_arm) begin
        if (d_cnt == 0) begin
          d_arm = 0; if (sel) late_sel++;
          miso = 1'b0; d_read = 1; d_falls = 0;
        end else d_cnt--;
      end
      if (sck != ps) begin
        if (edges > 0 && since != DIV) badhalf++;
        edges++; since = 1;
      end else since++;
      if (sck && !ps) begin rises++; if (!d_read) early++; end
      if (!sck && ps && d_read) begin
        d_falls++;
        miso = (d_falls <= 18) ? d_word[18 - d_falls] : 1'b1;
      end
      if (done) begin ndone++; got = data; end
      if (err) nerr++;
    end
    pc = cvt; ps = sck; psel = sel;
  end

  task automatic run(int ct, logic [17:0] w, bit poke);
    age = 0; sel_age = -1; fall_age = -1; rises = 0; early = 0; badhalf = 0;
    since = 0; edges = 0; ndone = 0; nerr = 0; late_sel = 0; rises_cvt = 0;
    sel_at = 0; sel_before = 0; fall_done = 0;
    d_word = w; d_time = ct;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; @(negedge clk) start = 1'b0;
    end
    for (int i = 0; i < 800 && ndone == 0 && nerr == 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    if (ct >= 0) begin
      chk(sel_at && sel_before, "R2 sel high around cvt rise", int'(sel_at), 1);
      chk(sel_age == SDI_HOLD, "R3 sel fall delay", sel_age, SDI_HOLD);
      chk(late_sel == 0, "R3 sel low at end of conversion", late_sel, 0);
      chk(fall_done, "R4 cvt falls with done", int'(fall_done), 1);
      chk(early == 0, "R5 no sck before busy low", early, 0);
      chk(rises == 19, "R6 sck period count", rises, 19);
      chk(badhalf == 0, "R6 half period length", badhalf, 0);
      chk(got == w, "R7 captured word", int'(got), int'(w));
      chk(ndone == 1, "R8 single done pulse", ndone, 1);
      chk(data == w, "R8 data held", int'(data), int'(w));
      if (poke) chk(rises_cvt == 1, "R10 busy start ignored", rises_cvt, 1);
    end else begin
      chk(nerr == 1, "R9 error pulse", nerr, 1);
      chk(fall_age == TMAX, "R9 timeout cycle", fall_age, TMAX);
      chk(rises == 0 && ndone == 0, "R9 no readback", rises + ndone, 0);
      if (poke) chk(rises_cvt == 1, "R10 busy start ignored", rises_cvt, 1);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    chk({cvt, sel, sck, done, err} == 5'b0, "R1 outputs in reset", int'({cvt, sel, sck, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cvt, sel, sck, done, err} == 5'b0, "R1 outputs after reset", int'({cvt, sel, sck, done, err}), 0);
    run(TMIN, 18'h00000, 0);
    run(TMIN, 18'h3ffff, 1);
    run(TMIN + 3, 18'h20001, 0);
    run(TMIN + 7, 18'h15555, 1);
    run(-1, 18'h0, 0);
    run(-1, 18'h0, 1);
    for (int k = 0; k < 12; k++)
      run(TMIN + int'($urandom % 20), 18'($urandom), k[0]);
    run(TMIN + 1, 18'h2aaaa, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule